// File: doc/BRIEF.md
# Lowest-Bit Mask Logic Unit

This block is a single-stage registered logic unit for the bit tricks that act on the lowest set bit or the lowest clear bit of an operand, plus an and-not. A request carries a valid strobe, a 4-bit operation code, a width select and two operands, `x` and `y`. Exactly one clock edge later, the unit presents the result, a zero flag and a carry flag, together with its own valid strobe. Only the and-not operation reads `y`. All other operations transform `x` alone.

Operands are 64 bits wide. A width select of 0 runs the operation at 32 bits. In that mode the upper operand bits are ignored, every increment and decrement wraps at 32 bits, and the upper half of the result is forced to zero. The unit suits an integer execution pipeline as one functional unit with a fixed latency of one cycle.

Top module: `lbm_unit`

## Requirements
- R1: A request with `in_valid`=1 sampled at a clock edge raises `out_valid` after that edge for exactly one cycle. When no request is sampled, `out_valid` is 0 after the edge and `out_res` and both flags keep their previous values.
- R2: Op code 0 (and-not) gives `~x & y`.
- R3: The lowest-set-bit group uses these op codes: 1 gives `x & -x`, 2 gives `x ^ (x-1)`, 3 gives `x & (x-1)`, 4 gives `x | (x-1)`, and 5 gives `~x | (x-1)`.
- R4: The lowest-clear-bit group uses these op codes: 6 gives `x & (x+1)`, 7 gives `~x & (x+1)`, 8 gives `x | ~(x+1)`, 9 gives `x ^ (x+1)`, and 10 gives `x | (x+1)`.
- R5: The trailing-run masks use these op codes: 11 gives `~x & (x-1)`, and 12 gives `~x | (x+1)`.
- R6: With `in_wide`=0, bits 63:32 of `x` and `y` have no effect, and arithmetic wraps at 32 bits. Bits 63:32 of the result are 0. With `in_wide`=1, all 64 bits take part.
- R7: `out_zf` is 1 exactly when the delivered result is zero.
- R8: `out_cf` is 1 exactly when the op code is in 1..5 and `x` is zero within the selected width. For every other op code, `out_cf` is 0.
- R9: Op codes 13, 14 and 15 give a zero result, with `out_zf`=1 and `out_cf`=0.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_res`, `out_zf` and `out_cf` to 0.
- R11: Op codes 1 and 7 always produce a result with at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| in_x | input | 64 | Source operand |
| in_y | input | 64 | Second operand (and-not only) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_res | output | 64 | Result |
| out_zf | output | 1 | Zero flag |
| out_cf | output | 1 | Carry flag (zero source, lowest-set group) |

## Verification
The zero flag and the carry flag can both be raised by a single request. This happens when a lowest-set-bit operation such as op 1 or op 3 receives a zero source. The bench provokes this in 64-bit mode with `x`=0. It also provokes it in 32-bit mode with a source whose only set bits lie above bit 31, so that the source counts as zero only after width masking. Each such result is judged against a scoreboard entry that expects the pair (zf=1, cf=1), while op 2 with the same source expects an all-ones result with cf=1 and zf=0.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    localparam int unsigned LBM_OP_W = 4;

    typedef enum logic [LBM_OP_W-1:0] {
        LBM_ANDN      = 4'd0,
        LBM_SET_ISO   = 4'd1,
        LBM_SET_MSK   = 4'd2,
        LBM_SET_CLR   = 4'd3,
        LBM_SET_FILL  = 4'd4,
        LBM_SET_ISOC  = 4'd5,
        LBM_CLR_FILL  = 4'd6,
        LBM_CLR_ISO   = 4'd7,
        LBM_CLR_ISOC  = 4'd8,
        LBM_CLR_MSK   = 4'd9,
        LBM_CLR_SET   = 4'd10,
        LBM_TZ_MSK    = 4'd11,
        LBM_TO_IMSK   = 4'd12,
        LBM_RSV13     = 4'd13,
        LBM_RSV14     = 4'd14,
        LBM_RSV15     = 4'd15
    } lbm_op_e;

    typedef enum logic {
        LBM_W32 = 1'b0,
        LBM_W64 = 1'b1
    } lbm_width_e;

    // True for the operations whose carry reports a zero source.
    function automatic logic lbm_set_group(input lbm_op_e op);
        return (op == LBM_SET_ISO) || (op == LBM_SET_MSK) ||
               (op == LBM_SET_CLR) || (op == LBM_SET_FILL) ||
               (op == LBM_SET_ISOC);
    endfunction

    function automatic logic lbm_single_bit_op(input lbm_op_e op);
        return (op == LBM_SET_ISO) || (op == LBM_CLR_ISO);
    endfunction

endpackage

// File: rtl/lbm_operand.sv
module lbm_operand #(
    parameter int unsigned DATA_W = 64
) (
    input  lbm_pkg::lbm_width_e width,
    input  logic [DATA_W-1:0]   x_in,
    input  logic [DATA_W-1:0]   y_in,
    output logic [DATA_W-1:0]   lane_mask,
    output logic [DATA_W-1:0]   x_m,
    output logic [DATA_W-1:0]   y_m,
    output logic [DATA_W-1:0]   x_dec,
    output logic [DATA_W-1:0]   x_inc
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Per-bit lane enable: upper half only participates in wide mode.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        if (i < HALF_W) begin : g_low
            assign lane_mask[i] = 1'b1;
        end else begin : g_high
            assign lane_mask[i] = (width == lbm_pkg::LBM_W64);
        end
    end

    assign x_m   = x_in & lane_mask;
    assign y_m   = y_in & lane_mask;
    // Full-width arithmetic; carries into the upper half are masked later.
    assign x_dec = x_m - ONE;
    assign x_inc = x_m + ONE;

endmodule

// File: rtl/lbm_transform.sv
module lbm_transform #(
    parameter int unsigned DATA_W = 64
) (
    input  lbm_pkg::lbm_op_e  op,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] x_m,
    input  logic [DATA_W-1:0] y_m,
    input  logic [DATA_W-1:0] x_dec,
    input  logic [DATA_W-1:0] x_inc,
    output logic [DATA_W-1:0] res
);
    import lbm_pkg::*;

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] x_neg;

    assign x_neg = ~x_dec;   // -x == ~(x-1)

    always_comb begin
        unique case (op)
            LBM_ANDN:     raw = ~x_m & y_m;
            LBM_SET_ISO:  raw = x_m & x_neg;
            LBM_SET_MSK:  raw = x_m ^ x_dec;
            LBM_SET_CLR:  raw = x_m & x_dec;
            LBM_SET_FILL: raw = x_m | x_dec;
            LBM_SET_ISOC: raw = ~x_m | x_dec;
            LBM_CLR_FILL: raw = x_m & x_inc;
            LBM_CLR_ISO:  raw = ~x_m & x_inc;
            LBM_CLR_ISOC: raw = x_m | ~x_inc;
            LBM_CLR_MSK:  raw = x_m ^ x_inc;
            LBM_CLR_SET:  raw = x_m | x_inc;
            LBM_TZ_MSK:   raw = ~x_m & x_dec;
            LBM_TO_IMSK:  raw = ~x_m | x_inc;
            default:      raw = '0;
        endcase
    end

    assign res = raw & lane_mask;

endmodule

// File: rtl/lbm_flags.sv
module lbm_flags #(
    parameter int unsigned DATA_W = 64
) (
    input  lbm_pkg::lbm_op_e  op,
    input  logic [DATA_W-1:0] x_m,
    input  logic [DATA_W-1:0] res,
    output logic              zf,
    output logic              cf
);
    assign zf = (res == '0);
    assign cf = lbm_pkg::lbm_set_group(op) && (x_m == '0);
endmodule

// File: rtl/lbm_unit.sv
module lbm_unit #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_y,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res,
    output logic              out_zf,
    output logic              out_cf
);
    import lbm_pkg::*;

    localparam int unsigned HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              zf;
        logic              cf;
    } lbm_result_t;

    lbm_op_e     op;
    lbm_width_e  width;
    logic [DATA_W-1:0] lane_mask, x_m, y_m, x_dec, x_inc, res_c;
    lbm_result_t next_q, cur_q;
    logic        valid_q;

    assign op    = lbm_op_e'(in_op);
    assign width = lbm_width_e'(in_wide);

    lbm_operand #(.DATA_W(DATA_W)) u_operand (
        .width(width), .x_in(in_x), .y_in(in_y), .lane_mask(lane_mask),
        .x_m(x_m), .y_m(y_m), .x_dec(x_dec), .x_inc(x_inc)
    );

    lbm_transform #(.DATA_W(DATA_W)) u_transform (
        .op(op), .lane_mask(lane_mask), .x_m(x_m), .y_m(y_m),
        .x_dec(x_dec), .x_inc(x_inc), .res(res_c)
    );

    lbm_flags #(.DATA_W(DATA_W)) u_flags (
        .op(op), .x_m(x_m), .res(res_c), .zf(next_q.zf), .cf(next_q.cf)
    );

    assign next_q.res = res_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cur_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) cur_q <= next_q;
        end
    end

    assign out_valid = valid_q;
    assign out_res   = cur_q.res;
    assign out_zf    = cur_q.zf;
    assign out_cf    = cur_q.cf;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_zf) && $stable(out_cf))); // R1
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide) |=> (out_res[DATA_W-1:HALF_W] == '0)); // R6
    AST_ZF_TRACKS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_zf == (out_res == '0))); // R7
    AST_CF_ONLY_SET_GROUP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !lbm_set_group(op)) |=> !out_cf); // R8
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > 4'd12) |=> (out_res == '0 && out_zf && !out_cf)); // R9
    AST_ISO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lbm_single_bit_op(op)) |=> $onehot0(out_res)); // R11

endmodule

// File: tb/tb_lbm_unit.sv
module tb_lbm_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic        in_wide = 1'b1;
    logic [63:0] in_x = '0;
    logic [63:0] in_y = '0;
    logic        out_valid;
    logic [63:0] out_res;
    logic        out_zf, out_cf;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [63:0] r;
        logic        z;
        logic        c;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    lbm_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
        .out_res(out_res), .out_zf(out_zf), .out_cf(out_cf)
    );

    function automatic exp_t model(input logic [3:0] op, input logic wide,
                                   input logic [63:0] x, input logic [63:0] y);
        exp_t e;
        logic [63:0] m, a, b, r;
        m = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        a = x & m;
        b = y & m;
        case (op)
            4'd0:  begin r = ~a & b;            e.tag = "R2"; end
            4'd1:  begin r = a & (~a + 64'd1);  e.tag = "R3"; end
            4'd2:  begin r = a ^ (a - 64'd1);   e.tag = "R3"; end
            4'd3:  begin r = a & (a - 64'd1);   e.tag = "R3"; end
            4'd4:  begin r = a | (a - 64'd1);   e.tag = "R3"; end
            4'd5:  begin r = ~a | (a - 64'd1);  e.tag = "R3"; end
            4'd6:  begin r = a & (a + 64'd1);   e.tag = "R4"; end
            4'd7:  begin r = ~a & (a + 64'd1);  e.tag = "R4"; end
            4'd8:  begin r = a | ~(a + 64'd1);  e.tag = "R4"; end
            4'd9:  begin r = a ^ (a + 64'd1);   e.tag = "R4"; end
            4'd10: begin r = a | (a + 64'd1);   e.tag = "R4"; end
            4'd11: begin r = ~a & (a - 64'd1);  e.tag = "R5"; end
            4'd12: begin r = ~a | (a + 64'd1);  e.tag = "R5"; end
            default: begin r = '0;              e.tag = "R9"; end
        endcase
        e.r = r & m;
        e.z = (e.r == 64'd0);
        e.c = (op >= 4'd1 && op <= 4'd5) && (a == 64'd0);
        if (!wide) e.tag = {e.tag, "/R6"};
        return e;
    endfunction

    task automatic send(input logic [3:0] op, input logic wide,
                        input logic [63:0] x, input logic [63:0] y, input exp_t e);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_wide  = wide;
        in_x     = x;
        in_y     = y;
        sb.push_back(e);
    endtask

    task automatic send_m(input logic [3:0] op, input logic wide,
                          input logic [63:0] x, input logic [63:0] y);
        send(op, wide, x, y, model(op, wide, x, y));
    endtask

    task automatic send_lit(input logic [3:0] op, input logic wide,
                            input logic [63:0] x, input logic [63:0] y,
                            input logic [63:0] r, input logic z, input logic c,
                            input string tag);
        exp_t e;
        e.r = r; e.z = z; e.c = c; e.tag = tag;
        send(op, wide, x, y, e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_x = ~in_x;
            in_op = in_op + 4'd1;
        end
    endtask

    // Monitor: pops and compares each delivered result (R1, R7, R8).
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1: unexpected out_valid, res=%h expected no result", out_res);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_res !== e.r || out_zf !== e.z || out_cf !== e.c) begin
                    fails++;
                    $display("FAIL %s/R7/R8: res=%h zf=%b cf=%b expected res=%h zf=%b cf=%b",
                             e.tag, out_res, out_zf, out_cf, e.r, e.z, e.c);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    logic [63:0] pats [8];
    logic [63:0] lfsr;

    initial begin : stim
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h8000_0000_0000_0000;
        pats[3] = 64'h0000_0000_0000_0058;
        pats[4] = 64'hFFFF_FFFF_0000_0000;
        pats[5] = 64'h0000_0000_FFFF_FFFF;
        pats[6] = 64'hA5A5_0F00_0000_0100;
        pats[7] = 64'h1234_5678_9ABC_DEF7;

        // R10: reset state
        in_valid = 1'b1; in_x = 64'h1; in_op = 4'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_res !== 64'd0 || out_zf !== 1'b0 || out_cf !== 1'b0) begin
            fails++;
            $display("FAIL R10: valid=%b res=%h zf=%b cf=%b expected all zero",
                     out_valid, out_res, out_zf, out_cf);
        end
        in_valid = 1'b0;
        rst = 1'b0;

        // Hand-worked values
        send_lit(4'd1,  1'b1, 64'h58, 64'h0, 64'h08, 1'b0, 1'b0, "R3 isolate");
        send_lit(4'd2,  1'b1, 64'h58, 64'h0, 64'h0F, 1'b0, 1'b0, "R3 mask");
        send_lit(4'd3,  1'b1, 64'h58, 64'h0, 64'h50, 1'b0, 1'b0, "R3 reset");
        send_lit(4'd11, 1'b1, 64'h58, 64'h0, 64'h07, 1'b0, 1'b0, "R5 tz mask");
        send_lit(4'd6,  1'b1, 64'h57, 64'h0, 64'h50, 1'b0, 1'b0, "R4 fill");
        send_lit(4'd7,  1'b1, 64'h57, 64'h0, 64'h08, 1'b0, 1'b0, "R4 isolate/R11");
        send_lit(4'd0,  1'b1, 64'hF0F0, 64'hFFFF, 64'h0F0F, 1'b0, 1'b0, "R2 andn");
        // R6: wrap at 32 bits versus 64
        send_lit(4'd9,  1'b0, 64'hFFFF_FFFF, 64'h0, 64'hFFFF_FFFF, 1'b0, 1'b0, "R6 wrap32");
        send_lit(4'd9,  1'b1, 64'hFFFF_FFFF, 64'h0, 64'h1_FFFF_FFFF, 1'b0, 1'b0, "R6 wide");
        // R8 + R7 in the same cycle, including upper bits ignored in narrow mode (R6)
        send_lit(4'd3,  1'b1, 64'h0, 64'h0, 64'h0, 1'b1, 1'b1, "R8 zf+cf");
        send_lit(4'd1,  1'b0, 64'hDEAD_0000_0000_0000, 64'h0, 64'h0, 1'b1, 1'b1, "R8 narrow zero/R6");
        send_lit(4'd2,  1'b0, 64'hDEAD_0000_0000_0000, 64'h0, 64'hFFFF_FFFF, 1'b0, 1'b1, "R8 mask cf");
        send_lit(4'd7,  1'b1, 64'h0, 64'h0, 64'h1, 1'b0, 1'b0, "R8 no cf clear group");
        send_lit(4'd14, 1'b1, 64'h0, 64'hFF, 64'h0, 1'b1, 1'b0, "R9 reserved");
        send_lit(4'd0,  1'b0, 64'hFFFF_0000_0000_0000, 64'hFFFF_FFFF_0000_00FF, 64'hFF, 1'b0, 1'b0, "R6 y upper ignored");

        // Sweep: every op, both widths, pattern operands, with gaps
        for (int w = 0; w < 2; w++)
            for (int op = 0; op < 16; op++)
                for (int p = 0; p < 8; p++) begin
                    send_m(4'(op), w[0], pats[p], pats[7 - p]);
                    if (p == 3) idle(1);
                end

        // Pseudo-random operands
        lfsr = 64'hACE1_2345_6789_BEEF;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            send_m(lfsr[3:0], lfsr[7], lfsr ^ {lfsr[31:0], lfsr[63:32]}, ~lfsr);
        end

        // R1: after the last request, idle cycles leave the outputs untouched
        idle(1);
        @(negedge clk);
        begin
            logic [63:0] held_r;
            logic        held_z, held_c;
            held_r = out_res; held_z = out_zf; held_c = out_cf;
            idle(3);
            checks++;
            if (out_valid !== 1'b0 || out_res !== held_r || out_zf !== held_z || out_cf !== held_c) begin
                fails++;
                $display("FAIL R1: idle valid=%b res=%h expected valid=0 res=%h", out_valid, out_res, held_r);
            end
        end
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d results missing, expected 0", sb.size());
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule